// File: doc/BRIEF.md
# Dual-Style Local Bus Master

This block is the master side of a 16-bit local bus on which address and data share the same wires. A host starts a transfer with a single command write. The command holds the start address, the word count, the direction, the transfer mode, the strobe style and the strobe timing. The block then runs the whole sequence of address and data phases on the bus. It sends write words from a host data port and returns each read word with a one-cycle valid pulse.

The block can drive either of two strobe styles:

- **Split-strobe style:** an address latch pulse, separate active-low read and write strobes, an active-low high-byte enable, and an active-high ready input.
- **Address-strobe style:** an active-low address strobe, upper and lower data strobes, a read/write direction line that is high for reads, and an active-low acknowledge input.

The pins of the style not in use stay idle. A timing field lets the block work with targets that cannot handshake. It also puts a bound on targets that acknowledge slowly.

There are three transfer modes:

- **Single:** one address phase and one data phase.
- **Incrementing block:** one address phase per word.
- **Non-incrementing burst:** one address phase, then every data phase at that same address.

Top module: `xbus_master`

## Requirements
- R1: While reset is held and at reset release, every output is inactive: busy, done, err, tmo, rd_valid, wr_take, latch_en and ad_oe are 0, and rd_n, wr_n, hib_n, astb_n, ustb_n, lstb_n and rw_n are 1.
- R2: With cmd_style=0, each address phase is one cycle with latch_en high and the address on ad_o (ad_oe=1). Then follows one cycle with no strobe. Then rd_n (read) or wr_n (write) goes low together with hib_n, and both strobes are never low at once. After each strobe there is one cycle with every strobe high. The address-strobe pins stay idle throughout.
- R3: With cmd_style=1, the address phase is one cycle with astb_n low and the address on ad_o. ustb_n and lstb_n go low together for each data strobe. rw_n equals cmd_read for the whole transfer. The split-strobe pins stay idle. The same one-cycle gaps as R2 apply.
- R4: cmd_mode=0 (single) gives exactly one address phase and one data phase, whatever the value of cmd_len.
- R5: cmd_mode=1 (incrementing block) gives cmd_len+1 address/data pairs. The address of pair k is cmd_addr+2k.
- R6: cmd_mode=2 (burst) gives one address phase at cmd_addr, followed by cmd_len+1 data phases.
- R7: With cmd_wait=0, a strobe stays asserted until the clock edge at which the acknowledge is seen. That is ready_i=1 in style 0 and ack_n_i=0 in style 1.
- R8: With cmd_wait=W>0 and cmd_hs=0, every strobe lasts exactly W cycles, and the acknowledge input is ignored.
- R9: With cmd_wait=W>0 and cmd_hs=1, a strobe ends at the earlier of the acknowledge or W cycles.
- R10: With cmd_wait=0, if no acknowledge arrives in 256 strobe cycles, the strobe is released and tmo pulses for one cycle. The bus goes idle (busy=0, ad_oe=0), and no done is given.
- R11: On a write, ad_o carries data word k from the set-up cycle to the hold cycle of data phase k. wr_take pulses once in each hold cycle, and the host then presents the next word on wr_data.
- R12: On a read, ad_oe stays 0 during the data phases. The value on ad_i at the edge that ends strobe k appears on rd_data with a one-cycle rd_valid pulse.
- R13: done pulses for one cycle after the last hold cycle. err pulses for one cycle when cmd_we arrives while busy or with cmd_mode=3 (reserved). Such a command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_addr | input | 16 | Start address (byte address) |
| cmd_len | input | 4 | Word count minus one |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_mode | input | 2 | 0 single, 1 incrementing block, 2 burst, 3 reserved |
| cmd_style | input | 1 | 0 split-strobe, 1 address-strobe |
| cmd_wait | input | 8 | Strobe cycle timer, 0 = handshake only |
| cmd_hs | input | 1 | Allow acknowledge to end a timed strobe |
| wr_data | input | 16 | Current write word from host buffer |
| wr_take | output | 1 | Current write word consumed |
| rd_data | output | 16 | Last read word |
| rd_valid | output | 1 | rd_data updated this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed pulse |
| err | output | 1 | Rejected command pulse |
| tmo | output | 1 | Acknowledge timeout pulse |
| ad_o | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for ad_o |
| ad_i | input | 16 | Multiplexed data in |
| latch_en | output | 1 | Split-strobe address latch pulse |
| rd_n | output | 1 | Split-strobe read strobe |
| wr_n | output | 1 | Split-strobe write strobe |
| hib_n | output | 1 | Split-strobe high-byte enable |
| ready_i | input | 1 | Split-strobe ready |
| astb_n | output | 1 | Address-strobe style address strobe |
| ustb_n | output | 1 | Upper data strobe |
| lstb_n | output | 1 | Lower data strobe |
| rw_n | output | 1 | Direction, high for read |
| ack_n_i | input | 1 | Address-strobe style acknowledge |

## Verification
The bench sweeps both styles, both directions, all three modes and word counts of one to three against five timing settings. A bus-side monitor measures every strobe length and compares it with the length computed from the wait value, the handshake flag and the target's acknowledge delay. This catches a design that lets an acknowledge cut a fixed-length strobe short, or that ends a strobe one cycle late. Address phases are counted and checked for value. A burst that re-sends the address, or a block that forgets to step by two, shows up as a wrong count or a wrong address. A missing set-up or hold gap, and a pin of the unused style that toggles, are counted as pin faults. A target that never acknowledges must lead to a 256-cycle strobe and a timeout with no done. A second command sent mid-transfer must be refused without disturbing the running transfer's addresses.

// File: rtl/xbus_pkg.sv
// Shared types for the local bus master: bus phase and transfer mode codes.
package xbus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } xb_phase_t;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_BLOCK  = 2'd1,
        XM_BURST  = 2'd2,
        XM_RSVD   = 2'd3
    } xb_mode_t;
endpackage

// File: rtl/xbus_timer.sv
// Strobe timer: counts cycles while a data strobe is active and decides when
// the strobe ends (acknowledge and/or programmed length) or times out.
// Assumes run is high exactly during the strobe phase.
module xbus_timer #(
    parameter int TW        = 8,
    parameter int TMO_LIMIT = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] wait_val,
    input  logic          hs,
    input  logic          ack,
    output logic          fin,
    output logic          expire
);
    localparam int CW = $clog2(TMO_LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          wait_zero;
    logic          timer_hit;
    logic          limit_hit;

    // Cycle counter, cleared whenever no strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign wait_zero = (wait_val == '0);
    assign timer_hit = (32'(cnt) + 32'd1) == 32'(wait_val);
    assign limit_hit = (32'(cnt) + 32'd1) == 32'(TMO_LIMIT);

    // End of strobe: acknowledge when handshaking applies, or timer expiry.
    always_comb begin
        fin    = run && ((ack && (hs || wait_zero)) || (!wait_zero && timer_hit));
        expire = run && wait_zero && !ack && limit_hit;
    end
endmodule

// File: rtl/xbus_seq.sv
// Transfer sequencer: accepts a command, steps through address, set-up,
// strobe and hold phases per word, and raises completion/error/timeout pulses.
// Assumes fin/expire come from the strobe timer for the current phase.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int DW = 16,
    parameter int LW = 4,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [DW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic          cmd_read,
    input  logic [1:0]    cmd_mode,
    input  logic          cmd_style,
    input  logic [TW-1:0] cmd_wait,
    input  logic          cmd_hs,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] ad_i,
    input  logic          fin,
    input  logic          expire,
    output xb_phase_t     phase,
    output logic          style_q,
    output logic          read_q,
    output logic [TW-1:0] wait_q,
    output logic          hs_q,
    output logic [DW-1:0] addr_q,
    output logic [DW-1:0] wdat_q,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          wr_take,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          tmo
);
    localparam logic [DW-1:0] ADDR_STEP = DW'(DW / 8);

    xb_mode_t      mode_q;
    logic [LW-1:0] left_q;
    xb_mode_t      cmd_mode_t;

    assign cmd_mode_t = xb_mode_t'(cmd_mode);

    // Phase stepping, command capture, data capture and status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            mode_q   <= XM_SINGLE;
            left_q   <= '0;
            style_q  <= 1'b0;
            read_q   <= 1'b0;
            wait_q   <= '0;
            hs_q     <= 1'b0;
            addr_q   <= '0;
            wdat_q   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            tmo      <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            tmo      <= 1'b0;
            err      <= cmd_we && (phase != PH_IDLE || cmd_mode_t == XM_RSVD);
            case (phase)
                PH_IDLE: begin
                    if (cmd_we && cmd_mode_t != XM_RSVD) begin
                        phase   <= PH_ADDR;
                        mode_q  <= cmd_mode_t;
                        left_q  <= (cmd_mode_t == XM_SINGLE) ? '0 : cmd_len;
                        style_q <= cmd_style;
                        read_q  <= cmd_read;
                        wait_q  <= cmd_wait;
                        hs_q    <= cmd_hs;
                        addr_q  <= cmd_addr;
                    end
                end
                PH_ADDR: begin
                    phase  <= PH_SETUP;
                    wdat_q <= wr_data;
                end
                PH_SETUP: phase <= PH_STROBE;
                PH_STROBE: begin
                    if (expire) begin
                        phase <= PH_IDLE;
                        tmo   <= 1'b1;
                    end else if (fin) begin
                        phase <= PH_HOLD;
                        if (read_q) begin
                            rd_data  <= ad_i;
                            rd_valid <= 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (left_q == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        left_q <= left_q - 1'b1;
                        if (mode_q == XM_BLOCK) begin
                            addr_q <= addr_q + ADDR_STEP;
                            phase  <= PH_ADDR;
                        end else begin
                            phase  <= PH_SETUP;
                            wdat_q <= wr_data;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign wr_take = (phase == PH_HOLD) && !read_q;
    assign busy    = (phase != PH_IDLE);
endmodule

// File: rtl/xbus_pins.sv
// Pin decoder: maps the current phase onto the strobes of the selected style
// and the shared address/data lines; folds the two acknowledge inputs into one.
// Assumes style/read are stable for a whole transfer.
module xbus_pins
    import xbus_pkg::*;
#(
    parameter int DW = 16
) (
    input  xb_phase_t     phase,
    input  logic          style,
    input  logic          read,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdat,
    input  logic          ready_i,
    input  logic          ack_n_i,
    output logic          ack,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    output logic          latch_en,
    output logic          rd_n,
    output logic          wr_n,
    output logic          hib_n,
    output logic          astb_n,
    output logic          ustb_n,
    output logic          lstb_n,
    output logic          rw_n
);
    logic drive_addr;
    logic drive_data;
    logic strobe;

    // Address/data line selection for the current phase.
    always_comb begin
        drive_addr = (phase == PH_ADDR);
        drive_data = !read && (phase == PH_SETUP || phase == PH_STROBE || phase == PH_HOLD);
        strobe     = (phase == PH_STROBE);
        ad_oe      = drive_addr || drive_data;
        ad_o       = drive_addr ? addr : (drive_data ? wdat : '0);
    end

    // Strobe outputs of the active style; the other style stays idle.
    always_comb begin
        latch_en = 1'b0;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        hib_n    = 1'b1;
        astb_n   = 1'b1;
        ustb_n   = 1'b1;
        lstb_n   = 1'b1;
        rw_n     = 1'b1;
        if (!style) begin
            latch_en = drive_addr;
            rd_n     = !(strobe && read);
            wr_n     = !(strobe && !read);
            hib_n    = !strobe;
        end else begin
            astb_n = !drive_addr;
            ustb_n = !strobe;
            lstb_n = !strobe;
            rw_n   = (phase == PH_IDLE) ? 1'b1 : read;
        end
    end

    assign ack = style ? !ack_n_i : ready_i;
endmodule

// File: rtl/xbus_master.sv
// Dual-style local bus master top: wires the sequencer, strobe timer and pin
// decoder. Assumes a single clock domain and synchronous active-low reset.
module xbus_master #(
    parameter int DW        = 16,
    parameter int LW        = 4,
    parameter int TW        = 8,
    parameter int TMO_LIMIT = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [DW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic          cmd_read,
    input  logic [1:0]    cmd_mode,
    input  logic          cmd_style,
    input  logic [TW-1:0] cmd_wait,
    input  logic          cmd_hs,
    input  logic [DW-1:0] wr_data,
    output logic          wr_take,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          tmo,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_i,
    output logic          latch_en,
    output logic          rd_n,
    output logic          wr_n,
    output logic          hib_n,
    input  logic          ready_i,
    output logic          astb_n,
    output logic          ustb_n,
    output logic          lstb_n,
    output logic          rw_n,
    input  logic          ack_n_i
);
    import xbus_pkg::*;

    xb_phase_t     phase;
    logic          style_q, read_q, hs_q, ack, fin, expire;
    logic [TW-1:0] wait_q;
    logic [DW-1:0] addr_q, wdat_q;

    xbus_seq #(.DW(DW), .LW(LW), .TW(TW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_read(cmd_read), .cmd_mode(cmd_mode),
        .cmd_style(cmd_style), .cmd_wait(cmd_wait), .cmd_hs(cmd_hs),
        .wr_data(wr_data), .ad_i(ad_i), .fin(fin), .expire(expire),
        .phase(phase), .style_q(style_q), .read_q(read_q), .wait_q(wait_q),
        .hs_q(hs_q), .addr_q(addr_q), .wdat_q(wdat_q), .rd_data(rd_data),
        .rd_valid(rd_valid), .wr_take(wr_take), .busy(busy), .done(done),
        .err(err), .tmo(tmo)
    );

    xbus_timer #(.TW(TW), .TMO_LIMIT(TMO_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(phase == PH_STROBE),
        .wait_val(wait_q), .hs(hs_q), .ack(ack), .fin(fin), .expire(expire)
    );

    xbus_pins #(.DW(DW)) u_pins (
        .phase(phase), .style(style_q), .read(read_q), .addr(addr_q),
        .wdat(wdat_q), .ready_i(ready_i), .ack_n_i(ack_n_i), .ack(ack),
        .ad_o(ad_o), .ad_oe(ad_oe), .latch_en(latch_en), .rd_n(rd_n),
        .wr_n(wr_n), .hib_n(hib_n), .astb_n(astb_n), .ustb_n(ustb_n),
        .lstb_n(lstb_n), .rw_n(rw_n)
    );
endmodule

// File: rtl/xbus_master_chk.sv
// Protocol checker for the local bus master, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module xbus_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_we,
    input logic busy,
    input logic done,
    input logic err,
    input logic tmo,
    input logic ad_oe,
    input logic latch_en,
    input logic rd_n,
    input logic wr_n,
    input logic hib_n,
    input logic astb_n,
    input logic ustb_n,
    input logic lstb_n,
    input logic rw_n
);
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R2
    AST_BYTE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !hib_n); // R2
    AST_STYLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en || !rd_n || !wr_n) |-> (astb_n && ustb_n && lstb_n && rw_n)); // R3
    AST_SETUP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en || !astb_n) |=> (rd_n && wr_n && ustb_n && lstb_n)); // R2
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || (!ustb_n && rw_n)) |-> !ad_oe); // R12
    AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> (!busy && !ad_oe && rd_n && wr_n && ustb_n && !done)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R13
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && busy) |=> err); // R13
endmodule

bind xbus_master xbus_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .busy(busy), .done(done),
    .err(err), .tmo(tmo), .ad_oe(ad_oe), .latch_en(latch_en), .rd_n(rd_n),
    .wr_n(wr_n), .hib_n(hib_n), .astb_n(astb_n), .ustb_n(ustb_n),
    .lstb_n(lstb_n), .rw_n(rw_n)
);

// File: tb/sim_xbus_master.sv
module sim_xbus_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [3:0]  cmd_len = '0;
    logic        cmd_read = 1'b0;
    logic [1:0]  cmd_mode = '0;
    logic        cmd_style = 1'b0;
    logic [7:0]  cmd_wait = '0;
    logic        cmd_hs = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] ad_i = '0;
    logic        ready_i = 1'b0;
    logic        ack_n_i = 1'b1;
    logic        wr_take, rd_valid, busy, done, err, tmo, ad_oe;
    logic        latch_en, rd_n, wr_n, hib_n, astb_n, ustb_n, lstb_n, rw_n;
    logic [15:0] rd_data, ad_o;

    always #4 clk = ~clk;

    xbus_master u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_read(cmd_read), .cmd_mode(cmd_mode),
        .cmd_style(cmd_style), .cmd_wait(cmd_wait), .cmd_hs(cmd_hs),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy), .done(done), .err(err), .tmo(tmo),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .latch_en(latch_en),
        .rd_n(rd_n), .wr_n(wr_n), .hib_n(hib_n), .ready_i(ready_i),
        .astb_n(astb_n), .ustb_n(ustb_n), .lstb_n(lstb_n), .rw_n(rw_n),
        .ack_n_i(ack_n_i)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int tid = 0;
    int n_addr, n_data, sc, n_take, n_rdv, n_done, n_tmo, n_err;
    int bad_addr, bad_wd, bad_rd, bad_len, bad_pin;
    bit mon_style = 0, mon_read = 0, prev_addr = 0;
    int mon_mode = 0, exp_len = 1, ack_d = 0;
    logic [15:0] mon_base = '0;

    function automatic logic [15:0] wword(int t, int k);
        return 16'(32'h3C00 + t * 37 + k * 32'h0111);
    endfunction

    function automatic logic [15:0] rword(int t, int k);
        return 16'(32'hA000 + t * 53 + k * 32'h0203);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // Bus-side target model and monitor, sampled away from the active edge.
    always @(negedge clk) begin
        bit s_act, a_act;
        s_act = mon_style ? !ustb_n : (!rd_n || !wr_n);
        a_act = mon_style ? !astb_n : latch_en;
        if (!mon_style) begin
            if (!(astb_n && ustb_n && lstb_n && rw_n)) bad_pin++;
            if (hib_n != !s_act) bad_pin++;
            if (mon_read ? !wr_n : !rd_n) bad_pin++;
        end else begin
            if (latch_en || !rd_n || !wr_n || !hib_n) bad_pin++;
            if (lstb_n != ustb_n) bad_pin++;
            if (s_act && rw_n != mon_read) bad_pin++;
        end
        if (prev_addr && s_act) bad_pin++;
        prev_addr = a_act;
        if (a_act) begin
            if (!ad_oe || ad_o != 16'(mon_base + (mon_mode == 1 ? 2 * n_addr : 0))) bad_addr++;
            n_addr++;
        end
        if (s_act) begin
            sc++;
            if (!mon_read && (!ad_oe || ad_o != wword(tid, n_data))) bad_wd++;
            if (mon_read && ad_oe) bad_pin++;
        end else if (sc != 0) begin
            if (sc != exp_len) bad_len++;
            n_data++;
            sc = 0;
        end
        ready_i <= s_act && (sc > ack_d);
        ack_n_i <= !(s_act && (sc > ack_d));
        ad_i    <= rword(tid, n_data);
        if (wr_take) n_take++;
        wr_data <= wword(tid, n_take);
        if (rd_valid) begin
            if (rd_data != rword(tid, n_rdv)) bad_rd++;
            n_rdv++;
        end
        if (done) n_done++;
        if (tmo) n_tmo++;
        if (err) n_err++;
    end

    task automatic clear_mon();
        n_addr = 0; n_data = 0; sc = 0; n_take = 0; n_rdv = 0;
        n_done = 0; n_tmo = 0; n_err = 0;
        bad_addr = 0; bad_wd = 0; bad_rd = 0; bad_len = 0; bad_pin = 0;
    endtask

    task automatic run(input bit sty, input bit rd, input int mode, input int len,
                       input int wt, input bit hs, input int d, input bit inject);
        int words, guard;
        bit tmo_exp;
        string ta, tl, tp;
        words   = (mode == 0) ? 1 : len + 1;
        tmo_exp = (wt == 0) && (d + 1 > 256);
        if (wt == 0)  exp_len = tmo_exp ? 256 : d + 1;
        else if (!hs) exp_len = wt;
        else          exp_len = (wt < d + 1) ? wt : d + 1;
        ta = (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R6";
        tl = (wt == 0) ? (tmo_exp ? "R10" : "R7") : (hs ? "R9" : "R8");
        tp = sty ? "R3" : "R2";
        tid++;
        clear_mon();
        mon_style = sty; mon_read = rd; mon_mode = mode; ack_d = d;
        mon_base = 16'(32'h0100 + tid * 64);
        @(negedge clk);
        cmd_addr = mon_base; cmd_len = 4'(len); cmd_read = rd;
        cmd_mode = 2'(mode); cmd_style = sty; cmd_wait = 8'(wt); cmd_hs = hs;
        cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            cmd_addr = 16'hFFF0; cmd_mode = 2'd1; cmd_we = 1'b1;
            @(negedge clk);
            cmd_we = 1'b0;
        end
        guard = 0;
        while (busy && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
        chk_eq({ta, " address phases"}, n_addr, tmo_exp ? 1 : (mode == 1 ? words : 1));
        chk_eq({ta, " address values"}, bad_addr, 0);
        chk_eq({ta, " data phases"}, n_data, tmo_exp ? 1 : words);
        chk_eq({tl, " strobe length"}, bad_len, 0);
        chk_eq({tp, " pin sequence"}, bad_pin, 0);
        chk_eq("R11 write data", bad_wd, 0);
        chk_eq("R11 take pulses", n_take, (rd || tmo_exp) ? 0 : words);
        chk_eq("R12 read data", bad_rd, 0);
        chk_eq("R12 valid pulses", n_rdv, (!rd || tmo_exp) ? 0 : words);
        chk_eq("R13 done pulses", n_done, tmo_exp ? 0 : 1);
        chk_eq("R10 timeout pulses", n_tmo, tmo_exp ? 1 : 0);
        chk_eq("R13 error pulses", n_err, inject ? 1 : 0);
    endtask

    initial begin
        int wts[5] = '{0, 0, 4, 5, 2};
        int hss[5] = '{0, 1, 0, 1, 1};
        int dls[5] = '{2, 0, 0, 1, 6};
        clear_mon();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !tmo && !rd_valid && !wr_take && !latch_en && !ad_oe
            && rd_n && wr_n && hib_n && astb_n && ustb_n && lstb_n && rw_n,
            "R1 outputs in reset", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && !ad_oe && rd_n && wr_n && ustb_n && !latch_en && astb_n,
            "R1 outputs after release", 0, 0);
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < 2; r++)
                for (int m = 0; m < 3; m++)
                    for (int l = 0; l < 3; l++)
                        for (int c = 0; c < 5; c++)
                            run(s[0], r[0], m, l, wts[c], hss[c][0], dls[c], 1'b0);
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < 2; r++)
                run(s[0], r[0], 1, 2, 0, 1'b0, 300, 1'b0);
        run(1'b0, 1'b0, 2, 2, 0, 1'b0, 3, 1'b1);
        run(1'b1, 1'b1, 1, 1, 3, 1'b1, 0, 1'b1);
        // Reserved mode is rejected and starts nothing.
        tid++;
        clear_mon();
        @(negedge clk);
        cmd_mode = 2'd3; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        chk_eq("R13 reserved mode busy", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk_eq("R13 reserved mode error", n_err, 1);
        chk_eq("R13 reserved mode no address", n_addr, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R13 watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule